// File: doc/BRIEF.md
# Power Domain Idle Controller

This block lets a processor core decide which of its four clock domains (CPU, DMA, cache and external memory interface) go to sleep. The core writes a configuration word through a small register port. It then raises an idle-instruction strobe, which moves that selection into a status word in one cycle. Each status bit drives the idle request of its domain, and the gating cells that act on those requests are outside the block.

Each domain is tracked by a two-state machine with states `DOM_RUN` and `DOM_IDLE`. There are two named transitions:

- **ENTER** goes from `DOM_RUN` to `DOM_IDLE`. It fires when the strobe arrives with the domain's selection bit set and no wake event for that domain.
- **RELEASE** goes from `DOM_IDLE` to `DOM_RUN`. It fires on a wake event for the domain, or when the strobe arrives with the selection bit clear.

Wake events reach the domains in two ways:

- A maskable interrupt wakes the CPU, DMA and cache domains.
- The external memory domain wakes only on its own wake input.

While the external memory domain sleeps, a separate output reports it. Software can use that output to hold off interrupt service code placed in external memory until that domain is awake again.

Top module: `dom_idle_ctrl`

## Requirements
- R1: After reset every idle request is 0, the external-memory hold output is 0, and both registers read as 0x0000.
- R2: The configuration register sits at address 0x0001 and can be read and written. The status register sits at address 0x0002 and can only be read. Both registers use the same bit positions: CPU at bit 0, DMA at bit 1, cache at bit 2 and external memory at bit 5. `acc_rdata` shows the addressed register while `acc_en`=1 and `acc_wr`=0, and shows 0x0000 otherwise.
- R3: Bits 3, 4 and 6 to 15 always read as 0, and writing them has no effect. Writes to the status address or to any address other than 0x0001 change nothing.
- R4: Writing the configuration register never changes the idle requests or the status register.
- R5: When the strobe is high at a clock edge, the status register takes the configuration value held before that edge. A write in the same cycle is not seen by that strobe. This sets the selected bits and clears the unselected ones, and the outputs change after that edge.
- R6: The outputs `idle_req[0]`, `idle_req[1]`, `idle_req[2]` and `idle_req[3]` follow the CPU, DMA, cache and external-memory status bits.
- R7: A cycle with `irq_wake` high clears the CPU, DMA and cache status bits and leaves the external-memory status bit as it was.
- R8: A cycle with `xmem_wake` high clears only the external-memory status bit. This input and reset are the only ways to clear that bit, apart from a strobe that copies a 0 into it.
- R9: When the strobe and a wake event fall in the same cycle, the wake event decides the bits it affects: those bits end up cleared.
- R10: `xmem_idle_hold` is 1 exactly when the external-memory status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access enable |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (16) | Register address |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data (combinational) |
| idle_strobe | input | 1 | Idle-instruction strobe |
| irq_wake | input | 1 | Maskable interrupt wake event |
| xmem_wake | input | 1 | Explicit external-memory wake |
| idle_req | output | 4 | Idle requests: [0] CPU, [1] DMA, [2] cache, [3] external memory |
| xmem_idle_hold | output | 1 | External memory domain is still idle |

## Verification
The assertions check several rules on every clock edge:

- The reserved read bits stay at zero.
- A configuration write with no strobe or wake leaves the idle requests unchanged.
- Every wake event clears its bits on the next edge, even against a strobe in the same cycle.
- An interrupt without an external-memory wake never disturbs the external-memory bit.
- An ENTER or RELEASE caused by the strobe lands one edge later.

Only the bench scenarios can show whole sequences. These include the status word read back after a strobe, a same-cycle write being missed by the strobe, ignored writes to the status address and to unmapped addresses, and the staged wake in which the CPU group resumes while external memory stays asleep until its own wake arrives.

// File: rtl/dom_idle_pkg.sv
package dom_idle_pkg;

    localparam int REG_W   = 16;
    localparam int NUM_DOM = 4;

    // domain index -> bit position inside both register words
    function automatic int dom_pos(input int d);
        case (d)
            0:       return 0;   // CPU
            1:       return 1;   // DMA
            2:       return 2;   // cache
            default: return 5;   // external memory interface
        endcase
    endfunction

    // 1: domain is woken by the maskable interrupt; 0: by the dedicated wake
    function automatic bit dom_irq_woken(input int d);
        return (d != NUM_DOM - 1);
    endfunction

    function automatic logic [REG_W-1:0] dom_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int d = 0; d < NUM_DOM; d++) m[dom_pos(d)] = 1'b1;
        return m;
    endfunction

    typedef enum logic {
        DOM_RUN  = 1'b0,
        DOM_IDLE = 1'b1
    } dom_state_e;

endpackage

// File: rtl/dom_idle_regs.sv
module dom_idle_regs
    import dom_idle_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [REG_W-1:0]  acc_wdata,
    input  logic [REG_W-1:0]  stat_word,
    output logic [REG_W-1:0]  cfg_q,
    output logic [REG_W-1:0]  acc_rdata
);

    localparam logic [REG_W-1:0] MASK = dom_mask();

    logic cfg_hit;
    assign cfg_hit = acc_en && acc_wr && (acc_addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (cfg_hit) cfg_q <= acc_wdata & MASK;
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_wr) begin
            if (acc_addr == CFG_ADDR)       acc_rdata = cfg_q & MASK;
            else if (acc_addr == STAT_ADDR) acc_rdata = stat_word & MASK;
        end
    end

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata & ~MASK) == '0);

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (cfg_q == ($past(acc_wdata) & MASK)));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(cfg_q));

endmodule

// File: rtl/dom_idle_cell.sv
module dom_idle_cell
    import dom_idle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic cfg_bit,
    input  logic wake,
    output logic idle
);

    dom_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DOM_RUN:  if (strobe && cfg_bit && !wake) state_d = DOM_IDLE;           // ENTER
            DOM_IDLE: if (wake || (strobe && !cfg_bit)) state_d = DOM_RUN;          // RELEASE
            default:  state_d = DOM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DOM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        idle = (state_q == DOM_IDLE);
    end

    // R9
    wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !idle);

    // R5
    enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cfg_bit && !wake) |=> idle);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cfg_bit) |=> !idle);

    // R4
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !wake) |=> $stable(idle));

endmodule

// File: rtl/dom_idle_ctrl.sv
module dom_idle_ctrl
    import dom_idle_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    input  logic              idle_strobe,
    input  logic              irq_wake,
    input  logic              xmem_wake,
    output logic [NUM_DOM-1:0] idle_req,
    output logic              xmem_idle_hold
);

    localparam int XMEM = NUM_DOM - 1;

    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] stat_word;

    dom_idle_regs #(
        .ADDR_W    (ADDR_W),
        .CFG_ADDR  (CFG_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .stat_word (stat_word),
        .cfg_q     (cfg_q),
        .acc_rdata (acc_rdata)
    );

    // R6: one state machine per domain
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic wake_d;
        if (dom_irq_woken(d)) begin : g_irq
            assign wake_d = irq_wake;        // R7
        end else begin : g_xmem
            assign wake_d = xmem_wake;       // R8
        end
        dom_idle_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (idle_strobe),
            .cfg_bit (cfg_q[dom_pos(d)]),
            .wake    (wake_d),
            .idle    (idle_req[d])
        );
    end

    always_comb begin
        stat_word = '0;
        for (int d = 0; d < NUM_DOM; d++) stat_word[dom_pos(d)] = idle_req[d];
    end

    // R10
    assign xmem_idle_hold = idle_req[XMEM];

    // R4
    cfg_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !idle_strobe && !irq_wake && !xmem_wake) |=> $stable(idle_req));

    // R7
    irq_keeps_xmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wake && !xmem_wake && !idle_strobe) |=> $stable(xmem_idle_hold));

    // R7
    irq_clears_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |=> (idle_req[XMEM-1:0] == '0));

    // R8
    xmem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xmem_wake && !irq_wake && !idle_strobe) |=> ($stable(idle_req[XMEM-1:0]) && !xmem_idle_hold));

endmodule

// File: tb/dom_idle_ctrl_bench.sv
module dom_idle_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [15:0] acc_addr = '0, acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        idle_strobe = 1'b0, irq_wake = 1'b0, xmem_wake = 1'b0;
    logic [3:0]  idle_req;
    logic        xmem_idle_hold;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [15:0] A_CFG  = 16'h0001;
    localparam logic [15:0] A_STAT = 16'h0002;

    always #4 clk = ~clk;   // 125 MHz

    dom_idle_ctrl u_dom_idle_ctrl (
        .clk(clk), .rst_n(rst_n),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .idle_strobe(idle_strobe), .irq_wake(irq_wake), .xmem_wake(xmem_wake),
        .idle_req(idle_req), .xmem_idle_hold(xmem_idle_hold)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] addr, input logic [15:0] exp, input string tag);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = addr;
        #1;
        check(tag, acc_rdata, exp);
        acc_en = 1'b0;
    endtask

    task automatic wr(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = addr; acc_wdata = data;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic events(input logic s, input logic iw, input logic xw);
        @(negedge clk);
        idle_strobe = s; irq_wake = iw; xmem_wake = xw;
        @(negedge clk);
        idle_strobe = 1'b0; irq_wake = 1'b0; xmem_wake = 1'b0;
    endtask

    task automatic outs(input logic [3:0] exp_req, input string tag);
        check({tag, " idle_req"}, {12'h0, idle_req}, {12'h0, exp_req});
        check({tag, " hold R10"}, {15'h0, xmem_idle_hold}, {15'h0, exp_req[3]});
    endtask

    task automatic t_reset;
        outs(4'b0000, "R1 reset");
        rd(A_CFG, 16'h0000, "R1 cfg after reset");
        rd(A_STAT, 16'h0000, "R1 stat after reset");
        rd(16'h0000, 16'h0000, "R2 unmapped read");
    endtask

    task automatic t_regs;
        wr(A_CFG, 16'hFFFF);
        rd(A_CFG, 16'h0027, "R3 reserved bits masked");
        outs(4'b0000, "R4 cfg write leaves status");
        rd(A_STAT, 16'h0000, "R4 stat after cfg write");
        wr(A_STAT, 16'h0027);
        rd(A_STAT, 16'h0000, "R3 stat not writable");
        wr(16'h0003, 16'h0000);
        rd(A_CFG, 16'h0027, "R3 unmapped write ignored");
        wr(A_CFG, 16'h0004);
        rd(A_CFG, 16'h0004, "R2 cfg readback");
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_addr = A_CFG;
        #1 check("R2 no read no data", acc_rdata, 16'h0000);
    endtask

    task automatic t_strobe_all;
        wr(A_CFG, 16'h0027);
        events(1'b1, 1'b0, 1'b0);
        outs(4'b1111, "R5 strobe all");
        rd(A_STAT, 16'h0027, "R6 stat after strobe");
    endtask

    task automatic t_staged_wake;
        events(1'b0, 1'b1, 1'b0);
        outs(4'b1000, "R7 irq keeps xmem");
        rd(A_STAT, 16'h0020, "R7 stat after irq");
        events(1'b0, 1'b1, 1'b0);
        outs(4'b1000, "R8 second irq no effect");
        events(1'b0, 1'b0, 1'b1);
        outs(4'b0000, "R8 xmem wake");
    endtask

    task automatic t_partial;
        wr(A_CFG, 16'h0021);
        events(1'b1, 1'b0, 1'b0);
        outs(4'b1001, "R5 cpu+xmem");
        wr(A_CFG, 16'h0002);
        outs(4'b1001, "R4 rewrite keeps status");
        events(1'b0, 1'b0, 1'b1);
        outs(4'b0001, "R8 xmem only");
        events(1'b1, 1'b0, 1'b0);
        outs(4'b0010, "R5 strobe clears unselected");
        events(1'b0, 1'b1, 1'b0);
        outs(4'b0000, "R7 irq clears dma");
    endtask

    task automatic t_collide;
        wr(A_CFG, 16'h0027);
        events(1'b1, 1'b1, 1'b0);
        outs(4'b1000, "R9 strobe+irq");
        events(1'b0, 1'b0, 1'b1);
        events(1'b1, 1'b0, 1'b1);
        outs(4'b0111, "R9 strobe+xmem wake");
        events(1'b0, 1'b1, 1'b0);
        // same-cycle write is not seen by the strobe
        wr(A_CFG, 16'h0004);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = A_CFG; acc_wdata = 16'h0021;
        idle_strobe = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; idle_strobe = 1'b0;
        outs(4'b0100, "R5 strobe uses old cfg");
        rd(A_CFG, 16'h0021, "R5 write still lands");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_strobe_all();
        t_staged_wake();
        t_partial();
        t_collide();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule